// File: doc/BRIEF.md
# Framebuffer Line-Burst Read Requester

This block drives the read-address channel of a video DMA engine. It walks a framebuffer held in memory one line at a time and issues AXI4 incrementing read bursts that fill a downstream receive FIFO. The frame base address, the byte distance between line starts, the number of bus words in each line and the number of lines in a frame are configuration inputs that can change at run time. Because of this, neither the start address of a line nor its length is known ahead of time. Each burst length is therefore worked out in a short pipeline. The tentative length is first capped by the words left in the line and then by the distance to the next burst-size boundary.

The block keeps a count of receive-FIFO space that is not yet promised to any burst. It issues a request only when a full maximum-length burst would still fit. An enable input starts frame walking from the base address. Dropping the enable, or pulsing a soft reset, stops new requests. Walking does not resume until every burst already requested has returned its last beat.

Top module: `fb_line_rd_req`

## Requirements
- R1: Out of reset `ar_valid` is low, `ar_burst` is 2'b01 (incrementing) and `ar_size` equals the log2 of the bus width in bytes.
- R2: The first burst after activation starts at the frame base address.
- R3: Each burst carries `ar_len`+1 beats, equal to the smallest of three values: the words left in the line, the maximum burst length, and the beats left before the next maximum-burst-aligned boundary. A burst therefore never crosses that boundary.
- R4: Within a line, each burst starts at the byte just after the previous burst ends, and the bursts of a line add up to exactly the configured words per line.
- R5: After the final burst of a line that is not the last line, the next burst starts at that line's start address plus the line step.
- R6: After the final burst of the last line, the next burst starts at the frame base address again.
- R7: Once raised, `ar_valid` stays high with `ar_addr` and `ar_len` unchanged until `ar_ready` is seen. A stall does not change the sequence of addresses.
- R8: Uncommitted space starts at the FIFO depth, drops by `ar_len`+1 when a burst is issued and rises by one for each `fifo_pop`. A burst is started only while that space is at least one maximum-length burst.
- R9: When `run` is low or `soft_rst` is high, no new burst starts. The walk restarts from the base only after every issued burst has returned `rd_last`.
- R10: The low address bits below the bus width in bytes are always zero on `ar_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enable frame walking |
| soft_rst | input | 1 | Stop issuing and restart from the base once idle |
| cfg_base | input | AW | Frame base byte address |
| cfg_step | input | AW | Byte distance between line starts |
| cfg_words | input | LW | Bus words per line (at least 1) |
| cfg_lines | input | LW | Lines per frame (at least 1) |
| fifo_pop | input | 1 | Consumer removed one word from the receive FIFO |
| rd_last | input | 1 | Last beat of a read burst returned |
| ar_ready | input | 1 | Read-address channel ready |
| ar_valid | output | 1 | Read-address channel valid |
| ar_addr | output | AW | Burst start byte address |
| ar_len | output | 8 | Beats in burst minus one |
| ar_burst | output | 2 | Burst type, always incrementing |
| ar_size | output | 3 | Beat size, log2 of bus bytes |

## Verification
The bench builds the block with 4-beat maximum bursts, 4-byte bus words, a 16-word receive FIFO and 16-bit addresses. These small values make boundary trimming show up on the first burst of a misaligned line. They also let the FIFO space run out after exactly four full bursts and let a whole frame wrap back to its base within a few dozen cycles. The restart gating can then be exercised while returned-burst signalling is held off.

// File: rtl/fbrd_pkg.sv
// Shared constants for the framebuffer line-burst read requester.
package fbrd_pkg;
    localparam logic [1:0] BURST_INCR = 2'b01;

    // Issue pipeline phase, for readability in the control logic.
    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_LAG   = 2'd1,
        PH_TRIM  = 2'd2,
        PH_ISSUE = 2'd3
    } ph_e;
endpackage

// File: rtl/fbrd_space.sv
// Uncommitted receive-FIFO space tracker.
// Starts at the FIFO depth, loses the beats of each issued burst, gains one
// per consumer pop. Assumes the consumer never pops more than was requested.
module fbrd_space #(
    parameter int LG_FIFO = 10,
    parameter int LG_MAXB = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [LG_MAXB:0]   take_beats,
    input  logic               pop,
    output logic               room_ok
);
    localparam int CW    = LG_FIFO + 1;
    localparam int DEPTH = 1 << LG_FIFO;
    localparam int MAXB  = 1 << LG_MAXB;

    logic [CW-1:0] space_q;

    // Space count: debit on issue, credit on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) space_q <= CW'(DEPTH);
        else        space_q <= space_q - (take ? CW'(take_beats) : '0) + CW'(pop);
    end

    assign room_ok = (space_q >= CW'(MAXB));

    // Issued beats must always have been covered by uncommitted space.
    assert_space_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (space_q >= CW'(take_beats)));
endmodule

// File: rtl/fbrd_len.sv
// Burst length pipeline.
// Lag cycle: cap a full burst by the words left in the line.
// Trim cycle: cap again by the beats left to the next burst boundary.
// Assumes the words-left input is nonzero while a line is in progress.
module fbrd_len #(
    parameter int LG_MAXB = 8,
    parameter int LW      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lag,
    input  logic               trim,
    input  logic [LW-1:0]      words_left,
    input  logic [LG_MAXB-1:0] beat_off,
    output logic [LG_MAXB:0]   beats
);
    localparam int BW   = LG_MAXB + 1;
    localparam int MAXB = 1 << LG_MAXB;

    logic [BW-1:0] to_bnd;
    assign to_bnd = BW'(MAXB) - BW'(beat_off);

    // Two-step tentative length register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats <= '0;
        end else if (lag) begin
            beats <= (words_left > LW'(MAXB)) ? BW'(MAXB) : BW'(words_left);
        end else if (trim) begin
            if (beats > to_bnd) beats <= to_bnd;
        end
    end

    // A trimmed length is never zero and never past a full burst.
    assert_len_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(trim) |-> (beats != '0 && beats <= BW'(MAXB)));
endmodule

// File: rtl/fbrd_walk.sv
// Frame address walker.
// Holds the next request address, the current line start, the words left in
// the line and the lines left in the frame. Advances on the internal issue
// cycle. Assumes cfg_words and cfg_lines are at least 1.
module fbrd_walk #(
    parameter int AW      = 32,
    parameter int LSB     = 2,
    parameter int LG_MAXB = 8,
    parameter int LW      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic [LG_MAXB:0] beats,
    input  logic [AW-1:0]    cfg_base,
    input  logic [AW-1:0]    cfg_step,
    input  logic [LW-1:0]    cfg_words,
    input  logic [LW-1:0]    cfg_lines,
    output logic [AW-1:0]    req_addr,
    output logic [LW-1:0]    words_left
);
    localparam logic [AW-1:0] WORD_MASK  = (AW'(1) << LSB) - AW'(1);
    localparam logic [AW-1:0] ALIGN_MASK = (AW'(1) << (LG_MAXB + LSB)) - AW'(1);

    logic [AW-1:0] line_start;
    logic [LW-1:0] lines_left;
    logic [AW-1:0] base_al, step_al, next_line;
    logic          line_end, last_line;

    assign base_al   = cfg_base & ~WORD_MASK;
    assign step_al   = cfg_step & ~WORD_MASK;
    assign next_line = line_start + step_al;
    assign line_end  = (words_left == LW'(beats));
    assign last_line = (lines_left == '0);

    // Position update: frame reload, line step, or in-line advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr   <= '0;
            line_start <= '0;
            words_left <= '0;
            lines_left <= '0;
        end else if (load || (adv && line_end && last_line)) begin
            req_addr   <= base_al;
            line_start <= base_al;
            words_left <= cfg_words;
            lines_left <= cfg_lines - LW'(1);
        end else if (adv && line_end) begin
            req_addr   <= next_line;
            line_start <= next_line;
            words_left <= cfg_words;
            lines_left <= lines_left - LW'(1);
        end else if (adv) begin
            req_addr   <= (req_addr + (AW'(beats) << LSB)) & ~ALIGN_MASK;
            words_left <= words_left - LW'(beats);
        end
    end

    // A mid-line advance always lands on a burst boundary.
    assert_midline_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !line_end && !load) |=> ((req_addr & ALIGN_MASK) == '0));
endmodule

// File: rtl/fb_line_rd_req.sv
// Framebuffer line-burst read requester (top).
// Sequences activation, the lag/trim length pipeline, the burst start, and
// the internal issue cycle. Registers the read-address channel outputs and
// counts bursts still awaiting their last beat.
// Assumes LW > LG_MAXB and LG_MAXB <= 8.
module fb_line_rd_req
    import fbrd_pkg::*;
#(
    parameter int AW           = 32,
    parameter int BUS_LG_BYTES = 2,
    parameter int LG_MAXB      = 8,
    parameter int LG_FIFO      = 10,
    parameter int LW           = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          soft_rst,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_step,
    input  logic [LW-1:0] cfg_words,
    input  logic [LW-1:0] cfg_lines,
    input  logic          fifo_pop,
    input  logic          rd_last,
    input  logic          ar_ready,
    output logic          ar_valid,
    output logic [AW-1:0] ar_addr,
    output logic [7:0]    ar_len,
    output logic [1:0]    ar_burst,
    output logic [2:0]    ar_size
);
    localparam int BW   = LG_MAXB + 1;
    localparam int CW   = LG_FIFO + 1;
    localparam int MAXB = 1 << LG_MAXB;

    logic          busy, phant_q, room_ok;
    ph_e           phase;
    logic [CW-1:0] out_cnt;
    logic [AW-1:0] req_addr;
    logic [LW-1:0] words_left;
    logic [BW-1:0] beats, issued_beats;
    logic          go_idle, activate, start, lag, trim;

    assign lag          = (phase == PH_LAG);
    assign trim         = (phase == PH_TRIM);
    assign go_idle      = busy && (!run || soft_rst);
    assign activate     = !busy && run && !soft_rst && (out_cnt == '0) && !ar_valid && !phant_q;
    assign start        = busy && !go_idle && (phase == PH_ISSUE) && !phant_q
                          && (!ar_valid || ar_ready) && room_ok;
    assign issued_beats = BW'(ar_len) + BW'(1);
    assign ar_burst     = BURST_INCR;
    assign ar_size      = 3'(BUS_LG_BYTES);

    // Activity flag and length-pipeline phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            phase <= PH_WAIT;
        end else begin
            if (activate)     busy <= 1'b1;
            else if (go_idle) busy <= 1'b0;
            if (go_idle)                                   phase <= PH_WAIT;
            else if (activate || (phant_q && busy))        phase <= PH_LAG;
            else if (phase == PH_LAG)                      phase <= PH_TRIM;
            else if (phase == PH_TRIM)                     phase <= PH_ISSUE;
            else if (start)                                phase <= PH_WAIT;
        end
    end

    // Internal issue marker, one cycle after each start.
    always_ff @(posedge clk) begin
        if (!rst_n) phant_q <= 1'b0;
        else        phant_q <= start;
    end

    // Read-address channel registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_valid <= 1'b0;
            ar_addr  <= '0;
            ar_len   <= '0;
        end else if (start) begin
            ar_valid <= 1'b1;
            ar_addr  <= req_addr;
            ar_len   <= 8'(beats - BW'(1));
        end else if (ar_ready) begin
            ar_valid <= 1'b0;
        end
    end

    // Bursts issued whose last beat has not returned.
    always_ff @(posedge clk) begin
        if (!rst_n) out_cnt <= '0;
        else        out_cnt <= out_cnt + CW'(phant_q) - CW'(rd_last);
    end

    fbrd_walk #(.AW(AW), .LSB(BUS_LG_BYTES), .LG_MAXB(LG_MAXB), .LW(LW)) i_walk (
        .clk(clk), .rst_n(rst_n), .load(activate), .adv(phant_q),
        .beats(issued_beats), .cfg_base(cfg_base), .cfg_step(cfg_step),
        .cfg_words(cfg_words), .cfg_lines(cfg_lines),
        .req_addr(req_addr), .words_left(words_left)
    );

    fbrd_len #(.LG_MAXB(LG_MAXB), .LW(LW)) i_len (
        .clk(clk), .rst_n(rst_n), .lag(lag), .trim(trim),
        .words_left(words_left), .beat_off(req_addr[BUS_LG_BYTES +: LG_MAXB]),
        .beats(beats)
    );

    fbrd_space #(.LG_FIFO(LG_FIFO), .LG_MAXB(LG_MAXB)) i_space (
        .clk(clk), .rst_n(rst_n), .take(phant_q), .take_beats(issued_beats),
        .pop(fifo_pop), .room_ok(room_ok)
    );

    // Stalled request holds its payload.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr) && $stable(ar_len)));

    // No burst crosses a maximum-burst boundary.
    assert_no_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> ((BW'(ar_addr[BUS_LG_BYTES +: LG_MAXB]) + BW'(ar_len)) < BW'(MAXB)));

    // Word-aligned request addresses.
    assert_word_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> (ar_addr[BUS_LG_BYTES-1:0] == '0));

    // Nothing new is raised while stopped.
    assert_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ar_valid) |=> !ar_valid);
endmodule

// File: tb/test_fb_line_rd_req.sv
module test_fb_line_rd_req;
    localparam int AW = 16, LSBB = 2, LGM = 2, LGF = 4, LW = 8;
    localparam int MAXB = 1 << LGM;

    logic          clk = 1'b0, rst_n = 1'b0, run = 1'b0, soft_rst = 1'b0;
    logic [AW-1:0] cfg_base = '0, cfg_step = '0;
    logic [LW-1:0] cfg_words = 8'd1, cfg_lines = 8'd1;
    logic          fifo_pop = 1'b0, rd_last = 1'b0, ar_ready = 1'b1;
    logic          ar_valid;
    logic [AW-1:0] ar_addr;
    logic [7:0]    ar_len;
    logic [1:0]    ar_burst;
    logic [2:0]    ar_size;

    fb_line_rd_req #(.AW(AW), .BUS_LG_BYTES(LSBB), .LG_MAXB(LGM), .LG_FIFO(LGF), .LW(LW))
    i_fb_line_rd_req (
        .clk(clk), .rst_n(rst_n), .run(run), .soft_rst(soft_rst),
        .cfg_base(cfg_base), .cfg_step(cfg_step), .cfg_words(cfg_words),
        .cfg_lines(cfg_lines), .fifo_pop(fifo_pop), .rd_last(rd_last),
        .ar_ready(ar_ready), .ar_valid(ar_valid), .ar_addr(ar_addr),
        .ar_len(ar_len), .ar_burst(ar_burst), .ar_size(ar_size)
    );

    always #4 clk = ~clk;  // 125 MHz

    int checks = 0, fails = 0;
    int hs = 0, owed = 0, pend = 0;
    bit auto_pop = 1'b1, ret_en = 1'b1;
    int m_addr, m_ls, m_wl, m_line;
    string m_tag;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_len();
        int l, tb;
        tb = MAXB - ((m_addr >> LSBB) % MAXB);
        l = m_wl;
        if (l > MAXB) l = MAXB;
        if (l > tb) l = tb;
        return l;
    endfunction

    task automatic model_reset();
        m_addr = int'(cfg_base); m_ls = m_addr; m_wl = int'(cfg_words);
        m_line = 0; m_tag = "R2";
    endtask

    function automatic void model_step(input int len);
        m_wl -= len;
        if (m_wl == 0) begin
            m_wl = int'(cfg_words);
            if (m_line == int'(cfg_lines) - 1) begin
                m_addr = int'(cfg_base); m_ls = m_addr; m_line = 0; m_tag = "R6";
            end else begin
                m_ls += int'(cfg_step); m_addr = m_ls; m_line++; m_tag = "R5";
            end
        end else begin
            m_addr += len << LSBB; m_tag = "R4";
        end
    endfunction

    // Handshake monitor and consumer / read-return model.
    always @(negedge clk) begin
        #1;
        if (rst_n && ar_valid && ar_ready) begin
            int len;
            len = int'(ar_len) + 1;
            chk(int'(ar_addr) == (m_addr & 16'hffff), m_tag, int'(ar_addr), m_addr);
            chk(len == exp_len(), "R3", len, exp_len());
            chk(ar_addr[LSBB-1:0] == '0, "R10", int'(ar_addr[LSBB-1:0]), 0);
            model_step(len);
            owed += len; pend++; hs++;
        end
        fifo_pop = auto_pop && owed > 0;
        if (fifo_pop) owed--;
        rd_last = ret_en && pend > 0;
        if (rd_last) pend--;
    end

    task automatic wait_hs(input int target, input string req);
        int n = 0;
        while (hs < target && n < 400) begin @(negedge clk); n++; end
        chk(hs >= target, req, hs, target);
    endtask

    task automatic quiesce();
        @(negedge clk); run = 1'b0; soft_rst = 1'b0; ar_ready = 1'b1;
        auto_pop = 1'b1; ret_en = 1'b1;
        repeat (20) @(negedge clk);
        while (owed != 0 || pend != 0) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic set_cfg(input int b, input int s, input int w, input int l);
        cfg_base = AW'(b); cfg_step = AW'(s); cfg_words = LW'(w); cfg_lines = LW'(l);
        model_reset();
    endtask

    task automatic t_reset();
        chk(!ar_valid, "R1", int'(ar_valid), 0);
        chk(ar_burst == 2'b01, "R1", int'(ar_burst), 1);
        chk(ar_size == 3'd2, "R1", int'(ar_size), 2);
    endtask

    // Aligned frame: two lines of two full bursts, then wrap (R2 R4 R5 R6).
    task automatic t_aligned();
        int h0;
        quiesce(); set_cfg('h100, 'h40, 8, 2);
        h0 = hs; run = 1'b1;
        wait_hs(h0 + 6, "R6");
    endtask

    // Misaligned start, odd line length (R3 R4 R5 R6).
    task automatic t_misaligned();
        int h0;
        quiesce(); set_cfg('h104, 'h40, 10, 2);
        h0 = hs; run = 1'b1;
        wait_hs(h0 + 8, "R3");
    endtask

    // Stall: payload held, sequence unaffected (R7).
    task automatic t_stall();
        logic [AW-1:0] a; logic [7:0] l; int h0, n = 0;
        quiesce(); set_cfg('h200, 'h20, 6, 3);
        ar_ready = 1'b0; h0 = hs; run = 1'b1;
        while (!ar_valid && n < 100) begin @(negedge clk); n++; end
        a = ar_addr; l = ar_len;
        repeat (5) begin
            @(negedge clk);
            chk(ar_valid && ar_addr == a && ar_len == l, "R7", int'(ar_addr), int'(a));
        end
        ar_ready = 1'b1;
        wait_hs(h0 + 7, "R7");
    endtask

    // Space gating: exactly four full bursts fit a 16-word FIFO (R8).
    task automatic t_space();
        int h0;
        quiesce(); set_cfg('h0, 'h20, 8, 2);
        auto_pop = 1'b0; h0 = hs; run = 1'b1;
        repeat (60) @(negedge clk);
        chk(hs - h0 == 4, "R8", hs - h0, 4);
        auto_pop = 1'b1;
        wait_hs(h0 + 8, "R8");
    endtask

    // Run drop, then restart gated by outstanding bursts (R9).
    task automatic t_run_drop();
        int n;
        quiesce(); set_cfg('h300, 'h40, 8, 2);
        ret_en = 1'b0; run = 1'b1;
        wait_hs(hs + 2, "R9");
        run = 1'b0;
        repeat (10) @(negedge clk);
        n = hs;
        repeat (30) @(negedge clk);
        chk(hs == n, "R9", hs - n, 0);
        model_reset(); run = 1'b1;
        repeat (30) @(negedge clk);
        chk(hs == n, "R9", hs - n, 0);
        ret_en = 1'b1;
        wait_hs(n + 3, "R9");
    endtask

    // Soft reset with a stalled request in flight (R9).
    task automatic t_soft();
        int n, k = 0;
        quiesce(); set_cfg('h400, 'h40, 8, 1);
        ar_ready = 1'b0; ret_en = 1'b0; run = 1'b1;
        while (!ar_valid && k < 100) begin @(negedge clk); k++; end
        n = hs;
        soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0; ar_ready = 1'b1;
        repeat (30) @(negedge clk);
        chk(hs == n + 1, "R9", hs - n, 1);
        model_reset(); ret_en = 1'b1;
        wait_hs(n + 4, "R9");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                t_aligned();
                t_misaligned();
                t_stall();
                t_space();
                t_run_drop();
                t_soft();
                quiesce();
            end
            begin
                repeat (150000) @(posedge clk);
                fails++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule